// File: doc/BRIEF.md
# Compare-Match Timer

A counter of configurable width (16 bits by default) that advances by one on every cycle in which its clock-enable tick is high. A mode code chosen by software selects how it counts. In free-running mode it runs to full scale and rolls back to zero. In clear-at-top mode it returns to zero after it reaches a top value. That top value comes either from compare register A or from a capture register that software writes.

A compare unit watches the count against compare register A. On a match it raises a sticky flag, and it drives one output pin according to a 2-bit action field: hold, toggle, clear or set. A force strobe applies the same action at once, without waiting for a match. A sticky overflow flag marks each roll-over to zero. Software can clear it directly, or through an interrupt-acknowledge input.

Top module: `cmp_timer`

## Requirements
- R1: Mode code 0, and every code other than 4 and 12, selects free-running counting. A tick at the all-ones count takes the count to 0.
- R2: The overflow flag goes to 1 on the clock that ends a tick taken at the all-ones count, so it rises together with the count reaching zero. Only `ovf_clr` or `ovf_ack` clears it. A set in the same cycle wins over a clear.
- R3: Mode code 4 selects clear-at-top with the top taken from compare register A. A live tick at a count equal to the top takes the count to 0.
- R4: Mode code 12 selects clear-at-top with the top taken from the capture register.
- R5: The match flag goes to 1 after a live tick at a count equal to compare register A, in every mode. `mtch_clr` clears it. A set in the same cycle wins over a clear.
- R6: On a match, the pin follows the action field: 00 holds it, 01 inverts it, 10 drives it to 0, 11 drives it to 1.
- R7: Writing the action field does not move the pin. The new action is first used at the next match or force.
- R8: A pulse on `force_a` applies the current action to the pin on the next clock, even without a tick. It leaves the match flag and the count unchanged.
- R9: A counter write loads the value on the next clock and wins over a tick in the same cycle. The first tick after the load is not live: it makes no match and no clear at the top, and the count only increments.
- R10: The count changes only on a tick or a counter write.
- R11: After reset, the count, the pin, both flags, compare register A and the capture register are 0. The mode is free-running and the action is hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable from the prescaler |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 16 | Counter write value |
| cmpa_we | input | 1 | Compare register A write strobe |
| cmpa_wdata | input | 16 | Compare register A value |
| cap_we | input | 1 | Capture register write strobe |
| cap_wdata | input | 16 | Capture register value |
| mode_we | input | 1 | Mode code write strobe |
| mode_wdata | input | 4 | Mode code |
| act_we | input | 1 | Action field write strobe |
| act_wdata | input | 2 | Action field |
| force_a | input | 1 | Force strobe: apply the action now |
| ovf_clr | input | 1 | Overflow flag clear by software write |
| ovf_ack | input | 1 | Overflow flag clear by interrupt acknowledge |
| mtch_clr | input | 1 | Match flag clear |
| cmp_pin | output | 1 | Compare output pin |
| count | output | 16 | Current count |
| ovf_flag | output | 1 | Overflow flag |
| match_flag | output | 1 | Compare A match flag |

## Verification
The assertions check on every cycle the properties that hold from one cycle to the next:
- the count holds without a tick or write;
- the count rolls over at full scale and clears at the top;
- a counter write lands;
- the flags set and stay set;
- each pin action matches its code;
- the pin stays quiet without a match or force.

Some behaviours depend on a history of several steps, so only the bench scenarios can show them:
- a new action taking effect only at a later match;
- the blocked tick after a load;
- each clear path of the overflow flag;
- the choice between the two top sources under long tick sequences.

// File: rtl/tmr_pkg.sv
// Shared types for the compare-match timer.
// Assumes mode codes are 4 bits wide; unknown codes fall back to free-running.
package tmr_pkg;

    localparam int MODE_W = 4;

    typedef enum logic [1:0] {
        TM_FREE    = 2'd0,
        TM_TOP_A   = 2'd1,
        TM_TOP_CAP = 2'd2
    } tmode_e;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } act_e;

    // Map the raw mode code to the counting behaviour.
    function automatic tmode_e decode_mode(input logic [MODE_W-1:0] code);
        case (code)
            4'd4:    return TM_TOP_A;
            4'd12:   return TM_TOP_CAP;
            default: return TM_FREE;
        endcase
    endfunction

endpackage

// File: rtl/tmr_counter.sv
// Counting core: increments on tick, rolls over at full scale or clears at a
// selected top, loads on a write and suppresses comparisons for the first tick
// after a load. Also holds the sticky overflow flag.
// Assumes the write strobe has priority over the tick.
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  tmode_e       mode,
    input  logic [W-1:0] top_a,
    input  logic [W-1:0] top_cap,
    input  logic         ovf_clr,
    input  logic         ovf_ack,
    output logic [W-1:0] count,
    output logic         live,
    output logic         ovf_flag
);

    localparam logic [W-1:0] FULL = {W{1'b1}};

    logic         blk;
    logic         step;
    logic         at_top;
    logic         roll;
    logic [W-1:0] top;

    // Choose the top source and detect the clear condition.
    always_comb begin
        top    = (mode == TM_TOP_CAP) ? top_cap : top_a;
        at_top = (mode != TM_FREE) && (count == top);
        step   = tick && !ld;
        live   = step && !blk;
        roll   = step && (count == FULL);
    end

    // Count register and post-load block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            blk   <= 1'b0;
        end else if (ld) begin
            count <= ld_val;
            blk   <= 1'b1;
        end else if (step) begin
            blk   <= 1'b0;
            count <= (live && at_top) ? '0 : count + 1'b1;
        end
    end

    // Sticky overflow flag; a set wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                 ovf_flag <= 1'b0;
        else if (roll)              ovf_flag <= 1'b1;
        else if (ovf_clr || ovf_ack) ovf_flag <= 1'b0;
    end

    assert_hold_no_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ld) |=> $stable(count));
    assert_free_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld && mode == TM_FREE && count == FULL) |=> (count == '0));
    assert_top_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (live && mode != TM_FREE && count == top) |=> (count == '0));
    assert_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (count == $past(ld_val)));
    assert_ovf_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        roll |=> ovf_flag);
    assert_ovf_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr && !ovf_ack) |=> ovf_flag);

endmodule

// File: rtl/tmr_match.sv
// Compare unit for register A: raises a hit on a live tick at equality and
// keeps a sticky match flag. Assumes live already excludes post-load ticks.
module tmr_match #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         live,
    input  logic [W-1:0] count,
    input  logic [W-1:0] cmpa,
    input  logic         flag_clr,
    output logic         hit,
    output logic         match_flag
);

    // Equality detection gated by a live tick.
    always_comb hit = live && (count == cmpa);

    // Sticky match flag; a set wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        match_flag <= 1'b0;
        else if (hit)      match_flag <= 1'b1;
        else if (flag_clr) match_flag <= 1'b0;
    end

    assert_hit_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> match_flag);
    assert_rise_at_equal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_flag) |-> $past(count == cmpa));

endmodule

// File: rtl/tmr_pin.sv
// Output unit: applies the action field to the pin on a hit or a force.
// Assumes the action field is sampled at the event, never on its write.
module tmr_pin
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic force_a,
    input  act_e act,
    output logic pin
);

    logic nxt;

    // Pin value the current action would produce.
    always_comb begin
        case (act)
            ACT_TOGGLE: nxt = ~pin;
            ACT_CLEAR:  nxt = 1'b0;
            ACT_SET:    nxt = 1'b1;
            default:    nxt = pin;
        endcase
    end

    // Pin register updated only on an event.
    always_ff @(posedge clk) begin
        if (!rst_n)              pin <= 1'b0;
        else if (hit || force_a) pin <= nxt;
    end

    assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && !force_a) |=> $stable(pin));
    assert_hold_act_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit || force_a) && act == ACT_HOLD) |=> $stable(pin));
    assert_set_act_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit || force_a) && act == ACT_SET) |=> pin);
    assert_clear_act_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit || force_a) && act == ACT_CLEAR) |=> !pin);
    assert_force_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (force_a && act == ACT_TOGGLE) |=> (pin != $past(pin)));

endmodule

// File: rtl/cmp_timer.sv
// Top of the compare-match timer: configuration registers, counting core,
// compare unit and output unit. Assumes all writes are single-cycle strobes.
module cmp_timer
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cnt_we,
    input  logic [W-1:0]      cnt_wdata,
    input  logic              cmpa_we,
    input  logic [W-1:0]      cmpa_wdata,
    input  logic              cap_we,
    input  logic [W-1:0]      cap_wdata,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              act_we,
    input  logic [1:0]        act_wdata,
    input  logic              force_a,
    input  logic              ovf_clr,
    input  logic              ovf_ack,
    input  logic              mtch_clr,
    output logic              cmp_pin,
    output logic [W-1:0]      count,
    output logic              ovf_flag,
    output logic              match_flag
);

    tmode_e       mode_q;
    act_e         act_q;
    logic [W-1:0] cmpa_q;
    logic [W-1:0] cap_q;
    logic         live;
    logic         hit;

    // Configuration registers written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= TM_FREE;
            act_q  <= ACT_HOLD;
            cmpa_q <= '0;
            cap_q  <= '0;
        end else begin
            if (mode_we) mode_q <= decode_mode(mode_wdata);
            if (act_we)  act_q  <= act_e'(act_wdata);
            if (cmpa_we) cmpa_q <= cmpa_wdata;
            if (cap_we)  cap_q  <= cap_wdata;
        end
    end

    tmr_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ld(cnt_we), .ld_val(cnt_wdata),
        .mode(mode_q), .top_a(cmpa_q), .top_cap(cap_q),
        .ovf_clr(ovf_clr), .ovf_ack(ovf_ack),
        .count(count), .live(live), .ovf_flag(ovf_flag)
    );

    tmr_match #(.W(W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .live(live), .count(count), .cmpa(cmpa_q),
        .flag_clr(mtch_clr), .hit(hit), .match_flag(match_flag)
    );

    tmr_pin u_pin (
        .clk(clk), .rst_n(rst_n), .hit(hit), .force_a(force_a), .act(act_q),
        .pin(cmp_pin)
    );

    assert_force_keeps_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (force_a && !tick && !cnt_we) |=> $stable(count));
    assert_force_no_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (force_a && !tick && !match_flag) |=> !match_flag);

endmodule

// File: tb/sim_cmp_timer.sv
module sim_cmp_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 0, cnt_we = 0, cmpa_we = 0, cap_we = 0, mode_we = 0, act_we = 0;
    logic [15:0] cnt_wdata = 0, cmpa_wdata = 0, cap_wdata = 0;
    logic [3:0]  mode_wdata = 0;
    logic [1:0]  act_wdata = 0;
    logic        force_a = 0, ovf_clr = 0, ovf_ack = 0, mtch_clr = 0;
    logic        cmp_pin, ovf_flag, match_flag;
    logic [15:0] count;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    cmp_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .cmpa_we(cmpa_we), .cmpa_wdata(cmpa_wdata), .cap_we(cap_we), .cap_wdata(cap_wdata),
        .mode_we(mode_we), .mode_wdata(mode_wdata), .act_we(act_we), .act_wdata(act_wdata),
        .force_a(force_a), .ovf_clr(ovf_clr), .ovf_ack(ovf_ack), .mtch_clr(mtch_clr),
        .cmp_pin(cmp_pin), .count(count), .ovf_flag(ovf_flag), .match_flag(match_flag)
    );

    typedef struct packed {
        logic [3:0]  mode;
        logic [1:0]  act;
        logic [15:0] cmpa;
        logic [15:0] cap;
        logic [15:0] pre;
        logic [7:0]  n;
        logic [15:0] e_cnt;
        logic        e_pin;
        logic        e_ovf;
        logic        e_mf;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{4'd0,  2'b01, 16'd5,    16'd0, 16'd0,      8'd10, 16'd10,   1'b1, 1'b0, 1'b1},
        '{4'd0,  2'b11, 16'd3,    16'd0, 16'hFFFD,   8'd5,  16'd2,    1'b0, 1'b1, 1'b0},
        '{4'd4,  2'b01, 16'd3,    16'd0, 16'd0,      8'd10, 16'd2,    1'b0, 1'b0, 1'b1},
        '{4'd12, 2'b11, 16'd2,    16'd4, 16'd0,      8'd7,  16'd2,    1'b1, 1'b0, 1'b1},
        '{4'd0,  2'b00, 16'd2,    16'd0, 16'd0,      8'd5,  16'd5,    1'b0, 1'b0, 1'b1},
        '{4'd7,  2'b01, 16'd3,    16'd0, 16'd0,      8'd6,  16'd6,    1'b1, 1'b0, 1'b1},
        '{4'd0,  2'b01, 16'd8,    16'd0, 16'd8,      8'd1,  16'd9,    1'b0, 1'b0, 1'b0},
        '{4'd4,  2'b01, 16'h10,   16'd0, 16'h20,     8'd3,  16'h23,   1'b0, 1'b0, 1'b0}
    };
    localparam string VREQ [NV] = '{"R1 R6", "R1 R2", "R3 R6", "R4 R6",
                                    "R6", "R1", "R9", "R3 R9"};

    task automatic clk1();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        clk1();
        clk1();
        rst_n = 1'b1;
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        for (int i = 0; i < n; i++) clk1();
        tick = 1'b0;
    endtask

    task automatic load(input logic [15:0] v);
        cnt_we = 1'b1; cnt_wdata = v;
        clk1();
        cnt_we = 1'b0;
    endtask

    task automatic config_all(input logic [3:0] m, input logic [1:0] a,
                              input logic [15:0] ca, input logic [15:0] cp);
        mode_we = 1; mode_wdata = m; act_we = 1; act_wdata = a;
        cmpa_we = 1; cmpa_wdata = ca; cap_we = 1; cap_wdata = cp;
        clk1();
        mode_we = 0; act_we = 0; cmpa_we = 0; cap_we = 0;
    endtask

    task automatic set_act(input logic [1:0] a);
        act_we = 1; act_wdata = a;
        clk1();
        act_we = 0;
    endtask

    task automatic pulse_force();
        force_a = 1;
        clk1();
        force_a = 0;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1;
        // Vector table walk: config, load, tick, compare final state.
        for (int v = 0; v < NV; v++) begin
            do_reset();
            config_all(VEC[v].mode, VEC[v].act, VEC[v].cmpa, VEC[v].cap);
            load(VEC[v].pre);
            ticks(int'(VEC[v].n));
            chk(VREQ[v], $sformatf("vec%0d count", v), count, VEC[v].e_cnt);
            chk(VREQ[v], $sformatf("vec%0d pin", v), 16'(cmp_pin), 16'(VEC[v].e_pin));
            chk(VREQ[v], $sformatf("vec%0d ovf", v), 16'(ovf_flag), 16'(VEC[v].e_ovf));
            chk("R5", $sformatf("vec%0d match flag", v), 16'(match_flag), 16'(VEC[v].e_mf));
        end

        // R11 reset state
        do_reset();
        chk("R11", "count", count, 16'd0);
        chk("R11", "pin", 16'(cmp_pin), 16'd0);
        chk("R11", "ovf", 16'(ovf_flag), 16'd0);
        chk("R11", "match", 16'(match_flag), 16'd0);

        // R9 load visible next clock; R10 no tick keeps count
        load(16'd7);
        chk("R9", "load value", count, 16'd7);
        for (int i = 0; i < 3; i++) clk1();
        chk("R10", "hold without tick", count, 16'd7);

        // R8 force without tick
        do_reset();
        set_act(2'b01);
        pulse_force();
        chk("R8", "force toggle pin", 16'(cmp_pin), 16'd1);
        chk("R8", "force no match flag", 16'(match_flag), 16'd0);
        chk("R8", "force keeps count", count, 16'd0);
        set_act(2'b10);
        pulse_force();
        chk("R8", "force clear pin", 16'(cmp_pin), 16'd0);
        set_act(2'b11);
        pulse_force();
        chk("R8", "force set pin", 16'(cmp_pin), 16'd1);

        // R7 action write waits for the next match (top A = 2, period 3)
        do_reset();
        config_all(4'd4, 2'b01, 16'd2, 16'd0);
        ticks(3);
        chk("R7", "first match toggles", 16'(cmp_pin), 16'd1);
        set_act(2'b10);
        chk("R7", "pin unmoved by action write", 16'(cmp_pin), 16'd1);
        ticks(3);
        chk("R7", "new action at next match", 16'(cmp_pin), 16'd0);
        // R5 clear of match flag
        mtch_clr = 1; clk1(); mtch_clr = 0;
        chk("R5", "match flag cleared", 16'(match_flag), 16'd0);

        // R2 both clear paths of the overflow flag
        do_reset();
        load(16'hFFFF);
        ticks(1);
        chk("R2", "overflow set", 16'(ovf_flag), 16'd1);
        chk("R1", "wrap to zero", count, 16'd0);
        ticks(2);
        chk("R2", "overflow sticky", 16'(ovf_flag), 16'd1);
        ovf_clr = 1; clk1(); ovf_clr = 0;
        chk("R2", "cleared by write", 16'(ovf_flag), 16'd0);
        load(16'hFFFF);
        ticks(1);
        ovf_ack = 1; clk1(); ovf_ack = 0;
        chk("R2", "cleared by acknowledge", 16'(ovf_flag), 16'd0);

        // R9 write during a tick wins, then counting resumes
        do_reset();
        tick = 1; clk1(); clk1();
        cnt_we = 1; cnt_wdata = 16'h0100; clk1(); cnt_we = 0;
        chk("R9", "write beats tick", count, 16'h0100);
        clk1();
        tick = 0;
        chk("R9", "count resumes after write", count, 16'h0101);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule